// File: doc/BRIEF.md
# Lost-Clock Supervisor

This block watches a monitored clock and asks for a system reset when that clock stops. It runs from its own free-running reference clock. Every rising edge of the monitored clock flips a toggle flag in the monitored domain. The reference domain passes that flag through a synchronizer and turns each change it sees into one accepted edge. A counter in the reference domain measures how many reference cycles pass without an accepted edge. When that number reaches the window parameter `WINDOW_CYCLES`, the block emits a one-cycle reset request. The window stands for the fixed time-out, so its value in cycles is the time-out divided by the reference period.

Software sets or clears `det_en` to turn the detector on or off. While the detector is off, the counter is held at zero and edges are ignored. When the detector is turned on, counting starts from zero, so it can never fire at once. After a request, the detector stays quiet until the monitored clock comes back, and then it counts a fresh window. The request is the block's only output, and the block has no path to the device's external reset pin.

Top module: `clk_loss_detector`

## Requirements
- R1: While `rst` is high, and on the first reference cycle after it falls, `rst_req` is 0. A monitored rising edge that occurs while `rst` is high is not counted.
- R2: While `det_en` is 0, `rst_req` stays 0 whatever the monitored clock does.
- R3: When `det_en` is sampled 1 after being 0, the count starts at zero. With no edges, `rst_req` is first high on the `WINDOW_CYCLES`-th reference rising edge after that sample, and never earlier.
- R4: `rst_req` rises on exactly the `WINDOW_CYCLES`-th consecutive reference cycle without an accepted edge. With accepted edges spaced `WINDOW_CYCLES` cycles apart, it never fires. With a spacing of `WINDOW_CYCLES`+1, it fires.
- R5: Each accepted edge restarts the count from zero. With the default `SYNC_STAGES`=2, a monitored rising edge is accepted on the third reference rising edge after it occurs.
- R6: `rst_req` is high for exactly one reference cycle per time-out.
- R7: After a request, `rst_req` stays 0 until an edge is accepted. After that edge, the next request comes `WINDOW_CYCLES` cycles later if no further edge arrives.
- R8: Clearing `det_en` in the middle of a count discards that count. Turning the detector on again behaves as in R3.
- R9: Monitored rising edges spaced at least two reference cycles apart are each accepted. A monitored clock running at that rate therefore never causes a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock that clocks the counter |
| rst | input | 1 | Synchronous active-high reset, reference domain |
| mon_clk | input | 1 | Clock being supervised |
| det_en | input | 1 | Detector enable (1 on, 0 off) |
| rst_req | output | 1 | One-cycle reset request, reference domain |

## Verification
The hardest case to reach is the exact boundary of the window. It needs edges that arrive exactly `WINDOW_CYCLES` or `WINDOW_CYCLES`+1 reference cycles apart, as the counter sees them, after the synchronizer delay. The bench reaches it by producing each monitored rising edge on a falling edge of the reference clock, so the acceptance cycle is known. It then spaces the pulses by the window and by one more than the window. A behavioural model tracks pending edges through a three-cycle delay line and predicts the request on every cycle, including a re-arm after a trip and a disable that falls in the middle of a count.

// File: rtl/clkmon_pkg.sv
package clkmon_pkg;

    typedef enum logic [1:0] {
        MD_IDLE = 2'd0,
        MD_RUN  = 2'd1,
        MD_TRIP = 2'd2
    } md_state_e;

    typedef struct packed {
        logic en;
        logic edge_seen;
    } md_event_t;

    function automatic int cnt_bits(input int n);
        int b;
        b = $clog2(n);
        if (b < 1) b = 1;
        return b;
    endfunction

endpackage

// File: rtl/clkmon_toggle.sv
module clkmon_toggle (
    input  logic mon_clk,
    input  logic rst,
    output logic tgl_o
);
    logic tgl_q;

    // Flip on every monitored rising edge; rst is quasi-static here.
    always_ff @(posedge mon_clk) begin
        if (rst) tgl_q <= 1'b0;
        else     tgl_q <= ~tgl_q;
    end

    assign tgl_o = tgl_q;
endmodule

// File: rtl/clkmon_sync.sv
module clkmon_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic ref_clk,
    input  logic rst,
    input  logic async_i,
    output logic edge_o
);
    localparam int CHAIN = SYNC_STAGES + 1;

    logic [CHAIN-1:0] chain_q;

    generate
        for (genvar i = 0; i < CHAIN; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge ref_clk) begin
                    if (rst) chain_q[0] <= 1'b0;
                    else     chain_q[0] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge ref_clk) begin
                    if (rst) chain_q[i] <= 1'b0;
                    else     chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign edge_o = chain_q[SYNC_STAGES-1] ^ chain_q[SYNC_STAGES];

    // R1
    reset_quiet_chk: assert property (@(posedge ref_clk) disable iff (rst)
        $past(rst) |-> !edge_o);

endmodule

// File: rtl/clkmon_timer.sv
module clkmon_timer
    import clkmon_pkg::*;
#(
    parameter int WINDOW_CYCLES = 1200
) (
    input  logic ref_clk,
    input  logic rst,
    input  logic en_i,
    input  logic edge_i,
    output logic req_o
);
    localparam int CW = cnt_bits(WINDOW_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(WINDOW_CYCLES - 1);

    md_event_t ev;
    md_state_e state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic req_q, req_d;

    assign ev.en = en_i;
    assign ev.edge_seen = edge_i;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        req_d   = 1'b0;
        if (!ev.en) begin
            state_d = MD_IDLE;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                MD_IDLE: begin
                    state_d = MD_RUN;
                    cnt_d   = '0;
                end
                MD_RUN: begin
                    if (ev.edge_seen) begin
                        cnt_d = '0;
                    end else if (cnt_q == LAST) begin
                        req_d   = 1'b1;
                        state_d = MD_TRIP;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + CW'(1);
                    end
                end
                MD_TRIP: begin
                    if (ev.edge_seen) begin
                        state_d = MD_RUN;
                        cnt_d   = '0;
                    end
                end
                default: begin
                    state_d = MD_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge ref_clk) begin
        if (rst) begin
            state_q <= MD_IDLE;
            cnt_q   <= '0;
            req_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            req_q   <= req_d;
        end
    end

    assign req_o = req_q;

    // R6
    req_pulse_chk: assert property (@(posedge ref_clk) disable iff (rst)
        req_o |=> !req_o);

    // R2
    dis_quiet_chk: assert property (@(posedge ref_clk) disable iff (rst)
        !en_i |=> !req_o);

    // R7
    trip_hold_chk: assert property (@(posedge ref_clk) disable iff (rst)
        (state_q == MD_TRIP && !edge_i) |=> !req_o);

    // R5
    retrig_chk: assert property (@(posedge ref_clk) disable iff (rst)
        (en_i && state_q == MD_RUN && edge_i) |=> (cnt_q == '0 && !req_o));

    // R3
    arm_chk: assert property (@(posedge ref_clk) disable iff (rst)
        (en_i && state_q == MD_IDLE) |=> (cnt_q == '0 && !req_o));

    // R4
    window_chk: assert property (@(posedge ref_clk) disable iff (rst)
        req_o |-> ($past(cnt_q) == LAST && state_q == MD_TRIP));

endmodule

// File: rtl/clk_loss_detector.sv
module clk_loss_detector
    import clkmon_pkg::*;
#(
    parameter int WINDOW_CYCLES = 1200,
    parameter int SYNC_STAGES   = 2
) (
    input  logic ref_clk,
    input  logic rst,
    input  logic mon_clk,
    input  logic det_en,
    output logic rst_req
);
    logic tgl;
    logic edge_pulse;

    clkmon_toggle u_toggle (
        .mon_clk (mon_clk),
        .rst     (rst),
        .tgl_o   (tgl)
    );

    clkmon_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .ref_clk (ref_clk),
        .rst     (rst),
        .async_i (tgl),
        .edge_o  (edge_pulse)
    );

    clkmon_timer #(.WINDOW_CYCLES(WINDOW_CYCLES)) u_timer (
        .ref_clk (ref_clk),
        .rst     (rst),
        .en_i    (det_en),
        .edge_i  (edge_pulse),
        .req_o   (rst_req)
    );

endmodule

// File: tb/clk_loss_detector_tb.sv
module clk_loss_detector_tb;
    localparam int W = 20;

    logic ref_clk = 1'b0;
    logic rst = 1'b1;
    logic mon_clk = 1'b0;
    logic det_en = 1'b0;
    logic rst_req;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    string tag = "R1";
    bit cmp_on = 1'b0;

    // behavioural model state
    bit pend = 0, d0 = 0, d1 = 0;
    bit m_active = 0, m_armed = 0, m_req = 0;
    int m_gap = 0;

    always #4 ref_clk = ~ref_clk;

    clk_loss_detector #(.WINDOW_CYCLES(W), .SYNC_STAGES(2)) u_dut (
        .ref_clk (ref_clk),
        .rst     (rst),
        .mon_clk (mon_clk),
        .det_en  (det_en),
        .rst_req (rst_req)
    );

    task automatic chk(input bit ok, input string rq, input int got, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s got=%0d expected=%0d at cycle %0d", rq, got, exp, cyc);
        end
    endtask

    // model: monitored edge accepted on third reference edge after it occurs
    always @(posedge ref_clk) begin
        bit e;
        cyc++;
        if (rst) begin
            pend = 0; d0 = 0; d1 = 0;
            m_active = 0; m_armed = 0; m_req = 0; m_gap = 0;
        end else begin
            e = d1; d1 = d0; d0 = pend; pend = 0;
            m_req = 0;
            if (!det_en) begin
                m_active = 0; m_armed = 0; m_gap = 0;
            end else if (!m_active) begin
                m_active = 1; m_armed = 1; m_gap = 0;
            end else if (e) begin
                m_armed = 1; m_gap = 0;
            end else if (m_armed) begin
                m_gap++;
                if (m_gap == W) begin
                    m_req = 1; m_armed = 0; m_gap = 0;
                end
            end
        end
    end

    always @(negedge ref_clk) begin
        if (cmp_on && !rst)
            chk(rst_req === m_req, tag, int'(rst_req), int'(m_req));
    end

    always @(posedge ref_clk) begin
        if (cyc > 100000) begin
            total++;
            bad++;
            $display("FAIL watchdog got=%0d expected=%0d", cyc, 100000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge ref_clk);
    endtask

    task automatic pulse();
        @(negedge ref_clk);
        mon_clk = 1'b1;
        if (!rst) pend = 1;
        @(negedge ref_clk);
        mon_clk = 1'b0;
    endtask

    task automatic pulses(input int n, input int spacing);
        for (int i = 0; i < n; i++) begin
            pulse();
            idle(spacing - 2);
        end
    endtask

    // count negedges until rst_req is seen high, capped
    task automatic wait_req(output int n);
        n = 0;
        do begin
            @(negedge ref_clk);
            n++;
        end while (rst_req !== 1'b1 && n < 4 * W);
    endtask

    initial begin
        int n;
        // R1: monitored edges during reset are not counted
        pulses(3, 2);
        idle(3);
        chk(rst_req === 1'b0, "R1", int'(rst_req), 0);
        @(negedge ref_clk);
        rst = 1'b0;
        @(negedge ref_clk);
        chk(rst_req === 1'b0, "R1", int'(rst_req), 0);
        cmp_on = 1'b1;

        // R2: disabled, edges and silence both ignored
        tag = "R2";
        pulses(5, 3);
        idle(3 * W);
        chk(rst_req === 1'b0, "R2", int'(rst_req), 0);

        // R3 / R4: enable then silence; request W+1 negedges after drive
        tag = "R3";
        det_en = 1'b1;
        wait_req(n);
        chk(n == W + 1, "R3", n, W + 1);
        @(negedge ref_clk);
        chk(rst_req === 1'b0, "R6", int'(rst_req), 0);

        // R7: tripped, silence gives no refire
        tag = "R7";
        idle(3 * W);
        chk(rst_req === 1'b0, "R7", int'(rst_req), 0);
        // R7: one edge re-arms; accepted 3 edges later, then W more
        pulse();
        // pulse drove mon high 2 negedges ago; acceptance at posedge +3, req W later
        n = 0;
        do begin
            @(negedge ref_clk);
            n++;
        end while (rst_req !== 1'b1 && n < 4 * W);
        chk(n == W + 2, "R7", n, W + 2);

        // R9: steady monitored clock, edges two cycles apart
        tag = "R9";
        pulses(60, 2);
        chk(rst_req === 1'b0, "R9", int'(rst_req), 0);

        // R5: edges at 15-cycle spacing keep retriggering
        tag = "R5";
        pulses(8, 15);
        chk(rst_req === 1'b0, "R5", int'(rst_req), 0);
        idle(2 * W);

        // R4 boundary: spacing W never fires, W+1 fires
        tag = "R4";
        pulse();
        idle(W + 6);
        pulses(6, W);
        chk(rst_req === 1'b0, "R4", int'(rst_req), 0);
        tag = "R4";
        pulses(4, W + 1);
        idle(2 * W);

        // R8: disable mid-count, re-enable restarts
        tag = "R8";
        pulse();
        idle(12);
        det_en = 1'b0;
        idle(5);
        chk(rst_req === 1'b0, "R8", int'(rst_req), 0);
        det_en = 1'b1;
        wait_req(n);
        chk(n == W + 1, "R8", n, W + 1);
        idle(W);

        // R6: repeated trips each one cycle wide
        tag = "R6";
        for (int k = 0; k < 3; k++) begin
            pulse();
            wait_req(n);
            @(negedge ref_clk);
            chk(rst_req === 1'b0, "R6", int'(rst_req), 0);
        end
        idle(5);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule